// File: doc/BRIEF.md
# Framed Byte-Port FPGA Configuration Loader

This block configures an attached FPGA over a byte-wide write port. On a start pulse it resets the target by pulling an active-low clear line for a programmable number of cycles. It then releases the line and waits for the target to report readiness. A timeout bounds that wait.

Once the target is ready, the loader writes a fixed eight-byte header. It then writes the bitstream, taken from a valid/ready byte source, in frames of 28 bytes. Each frame carries 21 payload bytes between a sync code and a check code, followed by five filler bytes. Before every frame the loader samples the target's ready and configured pins. It stops framing as soon as the target drops ready, reports configured, or the source has delivered its last byte. Four startup bytes close the load, and a single status cycle then sets either `done_o` or `error_o`.

Top module: `fpga_cfg_loader`

## Requirements
- R1: After reset, `tgt_reset_no` is high, `cfg_we_o` and `src_ready_o` are low, and `busy_o`, `done_o` and `error_o` are low.
- R2: A `start_i` pulse in idle drives `tgt_reset_no` low for exactly HOLD_CYCLES consecutive cycles, after which it is released high. No byte is written while it is low.
- R3: After release the loader waits for `tgt_ready_i` high. If it is still low after INIT_TIMEOUT cycles, the run ends with `error_o` high and no byte written.
- R4: The first eight bytes written are, in hex, FF FF FF 4F 80 AF 9B 4B, in that order.
- R5: Each frame is 28 bytes. Position 0 is 4F. Positions 1 to 21 carry payload in source order. Position 22 is 4B. Positions 23 to 27 are FF 4B FF FF FF.
- R6: A frame is started only when `tgt_ready_i` is high, `tgt_cfg_ok_i` is low and the source has not yet delivered a byte flagged last. Otherwise the loader goes straight to the startup bytes.
- R7: After the last frame, exactly four FF bytes are written.
- R8: In the status cycle after the startup bytes, `error_o` is set if `tgt_cfg_ok_i` is low or if the last source byte was never accepted; otherwise `done_o` is set. The two are never high together.
- R9: Payload positions after the source's last byte, within the final frame, are written as FF without consuming source bytes.
- R10: One byte is written per `cfg_we_o` cycle. A source byte is taken only when `src_valid_i` and `src_ready_o` are both high, and it appears on `cfg_byte_o` in that same cycle. While a payload position waits on a non-valid source, no byte is written.
- R11: `busy_o` is high from the cycle after `start_i` until the status cycle completes, and every byte write happens while busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse, honoured only in idle |
| tgt_ready_i | input | 1 | Target ready; low means not ready or error |
| tgt_cfg_ok_i | input | 1 | Target reports configuration complete |
| src_data_i | input | 8 | Bitstream byte |
| src_valid_i | input | 1 | Source byte valid |
| src_last_i | input | 1 | Marks the final source byte |
| src_ready_o | output | 1 | Loader takes the source byte this cycle |
| tgt_reset_no | output | 1 | Target clear line, active low |
| cfg_we_o | output | 1 | Byte write strobe |
| cfg_byte_o | output | 8 | Byte written to the target |
| busy_o | output | 1 | Load in progress |
| done_o | output | 1 | Last load succeeded |
| error_o | output | 1 | Last load failed |

## Verification
Payload lengths from 1 to 50 bytes are swept, both with a source that is always valid and with two irregular valid patterns. Lengths that fill a frame exactly are told apart from lengths that need FF padding, and stalls are shown not to disturb byte order. A target model drops ready, or reports configured, at chosen frame boundaries. This separates an early abort, which must leave data unsent and flag error, from a boundary at or past the final frame, which must still succeed. A target that never reports configured, and one that never becomes ready, cover the two remaining failure paths.

// File: rtl/cfgld_pkg.sv
package cfgld_pkg;
  localparam int HDR_LEN   = 8;
  localparam int FRAME_LEN = 28;
  localparam int PAY_LEN   = 21;
  localparam int TRL_LEN   = 4;
  localparam int IDX_W     = $clog2(FRAME_LEN);

  localparam logic [7:0] SYNC_CODE  = 8'h4F;
  localparam logic [7:0] CHECK_CODE = 8'h4B;
  localparam logic [7:0] FILL_CODE  = 8'hFF;

  typedef enum logic [2:0] {
    ST_IDLE, ST_CLEAR, ST_WAIT, ST_HDR, ST_GATE, ST_FRAME, ST_TRL, ST_CHECK
  } ld_state_e;

  function automatic logic [7:0] hdr_byte(input int idx);
    case (idx)
      3: hdr_byte = SYNC_CODE;
      4: hdr_byte = 8'h80;
      5: hdr_byte = 8'hAF;
      6: hdr_byte = 8'h9B;
      7: hdr_byte = CHECK_CODE;
      default: hdr_byte = FILL_CODE;
    endcase
  endfunction

  // fixed positions of a frame; payload slots return fill
  function automatic logic [7:0] frame_byte(input int idx);
    if (idx == 0) frame_byte = SYNC_CODE;
    else if (idx == PAY_LEN + 1 || idx == PAY_LEN + 3) frame_byte = CHECK_CODE;
    else frame_byte = FILL_CODE;
  endfunction
endpackage

// File: rtl/cfgld_timer.sv
module cfgld_timer #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  output logic         zero_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cnt_q <= '0;
    else if (load_i)      cnt_q <= val_i;
    else if (cnt_q != '0) cnt_q <= cnt_q - W'(1);
  end

  assign zero_o = (cnt_q == '0);

  // R2, R3: hold and timeout windows shrink by one per cycle
  assert_timer_step_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$past(load_i) && $past(cnt_q) != '0) |-> cnt_q == $past(cnt_q) - W'(1));
endmodule

// File: rtl/cfgld_code_gen.sv
module cfgld_code_gen
  import cfgld_pkg::*;
(
  input  ld_state_e        state_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic             pad_i,
  input  logic [7:0]       src_data_i,
  output logic             pay_slot_o,
  output logic [7:0]       byte_o
);
  always_comb begin
    pay_slot_o = (state_i == ST_FRAME) && (idx_i >= IDX_W'(1)) && (idx_i <= IDX_W'(PAY_LEN));
    case (state_i)
      ST_HDR:   byte_o = hdr_byte(int'(idx_i));
      ST_FRAME: byte_o = (pay_slot_o && !pad_i) ? src_data_i : frame_byte(int'(idx_i));
      default:  byte_o = FILL_CODE;
    endcase
  end
endmodule

// File: rtl/cfgld_seq.sv
module cfgld_seq
  import cfgld_pkg::*;
#(
  parameter int HOLD_CYCLES  = 125,
  parameter int INIT_TIMEOUT = 125000,
  parameter int TMR_W        = 17
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             tgt_ready_i,
  input  logic             tgt_cfg_ok_i,
  input  logic             src_valid_i,
  input  logic             src_last_i,
  input  logic             pay_slot_i,
  input  logic             tmr_zero_i,
  output logic             tmr_load_o,
  output logic [TMR_W-1:0] tmr_val_o,
  output ld_state_e        state_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             src_end_o,
  output logic             src_ready_o,
  output logic             tgt_reset_no,
  output logic             cfg_we_o,
  output logic             busy_o,
  output logic             done_o,
  output logic             error_o
);
  ld_state_e        state_q;
  logic [IDX_W-1:0] idx_q;
  logic             src_end_q, done_q, err_q;
  logic             frame_go;

  assign frame_go = tgt_ready_i && !tgt_cfg_ok_i && !src_end_q;

  always_comb begin
    src_ready_o = pay_slot_i && !src_end_q;
    case (state_q)
      ST_HDR, ST_TRL: cfg_we_o = 1'b1;
      ST_FRAME:       cfg_we_o = !src_ready_o || src_valid_i;
      default:        cfg_we_o = 1'b0;
    endcase
    tmr_load_o = (state_q == ST_IDLE && start_i) || (state_q == ST_CLEAR && tmr_zero_i);
    tmr_val_o  = (state_q == ST_IDLE) ? TMR_W'(HOLD_CYCLES - 1) : TMR_W'(INIT_TIMEOUT - 1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      idx_q     <= '0;
      src_end_q <= 1'b0;
      done_q    <= 1'b0;
      err_q     <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: if (start_i) begin
          state_q   <= ST_CLEAR;
          src_end_q <= 1'b0;
          done_q    <= 1'b0;
          err_q     <= 1'b0;
        end
        ST_CLEAR: if (tmr_zero_i) state_q <= ST_WAIT;
        ST_WAIT: begin
          idx_q <= '0;
          if (tgt_ready_i)     state_q <= ST_HDR;
          else if (tmr_zero_i) begin
            err_q   <= 1'b1;
            state_q <= ST_IDLE;
          end
        end
        ST_HDR: begin
          idx_q <= idx_q + IDX_W'(1);
          if (idx_q == IDX_W'(HDR_LEN - 1)) state_q <= ST_GATE;
        end
        ST_GATE: begin
          idx_q   <= '0;
          state_q <= frame_go ? ST_FRAME : ST_TRL;
        end
        ST_FRAME: begin
          if (src_ready_o && src_valid_i && src_last_i) src_end_q <= 1'b1;
          if (cfg_we_o) begin
            if (idx_q == IDX_W'(FRAME_LEN - 1)) begin
              idx_q   <= '0;
              state_q <= ST_GATE;
            end else idx_q <= idx_q + IDX_W'(1);
          end
        end
        ST_TRL: begin
          idx_q <= idx_q + IDX_W'(1);
          if (idx_q == IDX_W'(TRL_LEN - 1)) state_q <= ST_CHECK;
        end
        ST_CHECK: begin
          err_q   <= !tgt_cfg_ok_i || !src_end_q;
          done_q  <= tgt_cfg_ok_i && src_end_q;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign state_o      = state_q;
  assign idx_o        = idx_q;
  assign src_end_o    = src_end_q;
  assign tgt_reset_no = (state_q != ST_CLEAR);
  assign busy_o       = (state_q != ST_IDLE);
  assign done_o       = done_q;
  assign error_o      = err_q;

  assert_no_write_in_clear_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tgt_reset_no |-> !cfg_we_o);
  assert_write_while_busy_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_we_o |-> busy_o);
  assert_status_exclusive_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && error_o));
  assert_frame_gate_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_FRAME && $past(state_q) == ST_GATE) |->
      $past(tgt_ready_i && !tgt_cfg_ok_i && !src_end_q));
endmodule

// File: rtl/fpga_cfg_loader.sv
module fpga_cfg_loader
  import cfgld_pkg::*;
#(
  parameter int HOLD_CYCLES  = 125,
  parameter int INIT_TIMEOUT = 125000
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic       tgt_ready_i,
  input  logic       tgt_cfg_ok_i,
  input  logic [7:0] src_data_i,
  input  logic       src_valid_i,
  input  logic       src_last_i,
  output logic       src_ready_o,
  output logic       tgt_reset_no,
  output logic       cfg_we_o,
  output logic [7:0] cfg_byte_o,
  output logic       busy_o,
  output logic       done_o,
  output logic       error_o
);
  localparam int TMR_MAX = (HOLD_CYCLES > INIT_TIMEOUT) ? HOLD_CYCLES : INIT_TIMEOUT;
  localparam int TMR_W   = $clog2(TMR_MAX + 1);

  ld_state_e        state;
  logic [IDX_W-1:0] idx;
  logic             src_end, pay_slot, tmr_zero, tmr_load;
  logic [TMR_W-1:0] tmr_val;

  cfgld_timer #(.W(TMR_W)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (tmr_load),
    .val_i  (tmr_val),
    .zero_o (tmr_zero)
  );

  cfgld_code_gen u_code (
    .state_i    (state),
    .idx_i      (idx),
    .pad_i      (src_end),
    .src_data_i (src_data_i),
    .pay_slot_o (pay_slot),
    .byte_o     (cfg_byte_o)
  );

  cfgld_seq #(
    .HOLD_CYCLES  (HOLD_CYCLES),
    .INIT_TIMEOUT (INIT_TIMEOUT),
    .TMR_W        (TMR_W)
  ) u_seq (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_i      (start_i),
    .tgt_ready_i  (tgt_ready_i),
    .tgt_cfg_ok_i (tgt_cfg_ok_i),
    .src_valid_i  (src_valid_i),
    .src_last_i   (src_last_i),
    .pay_slot_i   (pay_slot),
    .tmr_zero_i   (tmr_zero),
    .tmr_load_o   (tmr_load),
    .tmr_val_o    (tmr_val),
    .state_o      (state),
    .idx_o        (idx),
    .src_end_o    (src_end),
    .src_ready_o  (src_ready_o),
    .tgt_reset_no (tgt_reset_no),
    .cfg_we_o     (cfg_we_o),
    .busy_o       (busy_o),
    .done_o       (done_o),
    .error_o      (error_o)
  );

  // R10: an accepted source byte goes out unchanged in the same cycle
  assert_accept_passthru_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (src_valid_i && src_ready_o) |-> (cfg_we_o && cfg_byte_o == src_data_i));
  // R9: once the source has ended it is never asked for more
  assert_no_pull_after_end_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    src_end |-> !src_ready_o);
endmodule

// File: tb/tb_fpga_cfg_loader.sv
`timescale 1ns/1ps
module tb_fpga_cfg_loader;
  localparam int HOLD = 4;
  localparam int TMO  = 40;
  localparam int NEVER = 1 << 30;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0, rdy = 1'b0, cfg_ok = 1'b0;
  logic [7:0] s_data = '0;
  logic s_valid = 1'b0, s_last = 1'b0;
  logic s_ready, reset_n, we, busy, done, err;
  logic [7:0] wbyte;

  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  fpga_cfg_loader #(.HOLD_CYCLES(HOLD), .INIT_TIMEOUT(TMO)) dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .tgt_ready_i(rdy),
    .tgt_cfg_ok_i(cfg_ok), .src_data_i(s_data), .src_valid_i(s_valid),
    .src_last_i(s_last), .src_ready_o(s_ready), .tgt_reset_no(reset_n),
    .cfg_we_o(we), .cfg_byte_o(wbyte), .busy_o(busy), .done_o(done), .error_o(err)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [7:0] pay(input int i);
    return 8'((i * 37 + 11) & 255);
  endfunction

  function automatic logic [7:0] exp_byte(input int p, input int len, input int nfr);
    int f, k;
    if (p < 8) begin
      case (p)
        3: return 8'h4F; 4: return 8'h80; 5: return 8'hAF;
        6: return 8'h9B; 7: return 8'h4B; default: return 8'hFF;
      endcase
    end
    if (p >= 8 + 28 * nfr) return 8'hFF;
    f = (p - 8) / 28;
    k = (p - 8) % 28;
    if (k == 0) return 8'h4F;
    if (k <= 21) return ((f * 21 + k - 1) < len) ? pay(f * 21 + k - 1) : 8'hFF;
    if (k == 22 || k == 24) return 8'h4B;
    return 8'hFF;
  endfunction

  function automatic string req_of(input int p, input int len, input int nfr);
    int k;
    if (p < 8) return "R4";
    if (p >= 8 + 28 * nfr) return "R7";
    k = (p - 8) % 28;
    if (k >= 1 && k <= 21 && ((p - 8) / 28 * 21 + k - 1) >= len) return "R9";
    return "R5";
  endfunction

  // one load; cut_k frames before target event (cut_kind 0: cfg_ok high, 1: ready drops)
  task automatic run(input int len, input int stall, input int cut_k, input int cut_kind,
                     input bit never_ok, input bit never_rdy);
    int full, nfr, done_at, drop_at, strobes, ptr, lowcnt, since, cyc, bad, first_bad;
    logic [7:0] first_act;
    bit exp_err, seen_busy, ended;
    full = (len + 20) / 21;
    nfr  = (cut_k >= 0 && cut_k < full) ? cut_k : full;
    done_at = never_ok ? NEVER : ((cut_kind == 0 && cut_k >= 0) ? 8 + 28 * cut_k : 8 + 28 * full);
    drop_at = (cut_kind == 1 && cut_k >= 0) ? 8 + 28 * cut_k : NEVER;
    exp_err = never_ok || never_rdy || (nfr < full);
    strobes = 0; ptr = 0; lowcnt = 0; since = 0; bad = 0; first_bad = -1; first_act = '0;
    seen_busy = 0; ended = 0;
    @(negedge clk);
    rdy = 1'b0; cfg_ok = 1'b0; start = 1'b1;
    for (cyc = 0; cyc < 6000 && !ended; cyc++) begin
      @(negedge clk);
      if (cyc == 0) start = 1'b0;
      if (!reset_n) begin lowcnt++; since = 0; end else since++;
      rdy = (lowcnt > 0) && reset_n && !never_rdy && since >= 3 && strobes < drop_at;
      cfg_ok = strobes >= done_at;
      s_valid = (ptr < len) && ((stall == 0) || (((cyc * 7 + stall) % 3) != 0));
      s_data  = (ptr < len) ? pay(ptr) : 8'h00;
      s_last  = (ptr == len - 1);
      #1;
      if (busy) seen_busy = 1;
      if (we) begin
        if (wbyte !== exp_byte(strobes, len, nfr)) begin
          if (first_bad < 0) begin first_bad = strobes; first_act = wbyte; end
          bad++;
        end
        strobes++;
      end
      if (s_valid && s_ready) ptr++;
      if (seen_busy && !busy) ended = 1;
    end
    s_valid = 1'b0; s_last = 1'b0;
    chk(ended, "watchdog", cyc, 0);
    chk(lowcnt == HOLD, "R2", lowcnt, HOLD);
    chk(seen_busy, "R11", seen_busy, 1);
    if (never_rdy) begin
      chk(strobes == 0, "R3", strobes, 0);
      chk(err && !done, "R3", {done, err}, 1);
    end else begin
      chk(strobes == 8 + 28 * nfr + 4, (nfr < full) ? "R6" : "R7", strobes, 8 + 28 * nfr + 4);
      if (first_bad >= 0)
        chk(0, req_of(first_bad, len, nfr), first_act, exp_byte(first_bad, len, nfr));
      else chk(1, "R5", 0, 0);
      chk(ptr == ((len < nfr * 21) ? len : nfr * 21), "R10", ptr,
          (len < nfr * 21) ? len : nfr * 21);
      chk(err == exp_err && done == !exp_err, "R8", {done, err}, exp_err ? 1 : 2);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 200000, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(reset_n && !we && !s_ready && !busy && !done && !err, "R1",
        {reset_n, we, s_ready, busy, done, err}, 32);
    // R4 R5 R7 R9 R10: length sweep with differing stall patterns
    for (int len = 1; len <= 50; len++) run(len, len % 3, -1, 0, 0, 0);
    run(63, 0, -1, 0, 0, 0);
    // R6: target reports configured early, leaving data unsent
    run(50, 0, 1, 0, 0, 0);
    run(10, 1, 0, 0, 0, 0);
    // R6: target drops ready after a frame
    run(60, 2, 1, 1, 0, 0);
    run(30, 0, 0, 1, 0, 0);
    // boundary at final frame: no effect
    run(30, 1, 2, 1, 0, 0);
    // R8: target never configured
    run(5, 0, -1, 0, 1, 0);
    // R3: target never ready
    run(5, 0, -1, 0, 0, 1);
    // R8 success after a failed run clears status
    run(21, 0, -1, 0, 0, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule